// File: doc/BRIEF.md
# Two-Level ATM Header Address Compressor

This block turns the routing fields of an arriving ATM cell into a compact channel code. It reads two tables from memory. The cell's port number, VPI and VCI arrive together on a request handshake. First, a programmable mask picks scattered bits out of the port-plus-VPI key. Those bits are packed into an index into a virtual-path table, which is read through a synchronous 32-bit port. The returned entry supplies a second mask and a byte offset. The second mask picks bits out of the VCI, and the packed result, together with the offset, addresses a virtual-channel table. That second read yields the channel code and a flag that marks whether the connection is known.

Two banks of table base addresses exist. The top bit of the port number chooses between them, so more than sixteen ports can be served. A single-port configuration ignores the port number entirely. The response stays on the outputs until the consumer acknowledges it. One lookup is in flight at a time.

Top module: `atm_addr_compressor`

## Requirements
- R1: During reset and until the internal reset release completes, `rsp_valid`, `mem_rd_en` and `req_ready` are 0. A few cycles after `rst_n` rises, `req_ready` is 1.
- R2: With `multi_port`=1, the first-level key is {`req_port[3:0]`, `req_vpi[11:0]`} (port nibble in key bits 15:12). The first read address is the selected VP base plus 4 times the index formed from the key bits where `vp_mask` is 1.
- R3: With `multi_port`=1, `req_port[4]`=0 selects bases `vpt_base0`/`vct_base0` and `req_port[4]`=1 selects `vpt_base1`/`vct_base1`. With `multi_port`=0, the key's port nibble is 0 and set 0 is used, whatever `req_port` holds.
- R4: The VP entry carries the VC mask in bits 31:16 and a byte offset in bits 15:0. The second read address is the selected VC base, plus the zero-extended offset, plus 4 times the index formed from the VCI bits where the VC mask is 1. Addresses wrap modulo 2^32.
- R5: `rsp_code` equals bits 31:16 of the VC entry and `rsp_miss` equals bit 0 (1 = no match, 0 = match). Bits 15:1 of the VC entry have no effect on the outputs.
- R6: Each lookup performs exactly two reads. Each read strobe `mem_rd_en` lasts one cycle, and the data is taken on the following edge. `rsp_valid` rises on the 4th rising edge after the edge that accepts the request.
- R7: `req_ready` is 1 only while no lookup is in flight or pending acknowledgement. A request held valid during a lookup is not taken and does not change the result.
- R8: While `rsp_valid`=1 and `rsp_ack`=0, `rsp_valid`, `rsp_code` and `rsp_miss` hold. An edge with `rsp_ack`=1 clears `rsp_valid` and raises `req_ready`.
- R9: Index packing is ascending: the lowest selected bit becomes index bit 0. A mask of 0 gives index 0, a mask of all ones passes the field through, and a mask of 0x07F0 gives bits 10:4 as a 7-bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| multi_port | input | 1 | 1: port number enters the key; 0: single-port mode |
| vp_mask | input | 16 | Bit selector over the {port nibble, VPI} key |
| vpt_base0 | input | 32 | VP table byte base, set 0 |
| vct_base0 | input | 32 | VC table byte base, set 0 |
| vpt_base1 | input | 32 | VP table byte base, set 1 |
| vct_base1 | input | 32 | VC table byte base, set 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_port | input | 5 | Physical port number |
| req_vpi | input | 12 | Virtual path identifier |
| req_vci | input | 16 | Virtual channel identifier |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | 32 | Table byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | Response present |
| rsp_ack | input | 1 | Response consumed |
| rsp_code | output | 16 | Channel code |
| rsp_miss | output | 1 | 1 = no match found |

## Verification
The hardest situation to reach from the ports is a wide spread of second-level masks and offsets. Those come out of memory, not from any input. The bench memory model returns a hash of each word address, so sweeping the first-level key lands on many different VP entries. Each of those entries carries its own scattered VC mask, unaligned offset and reserved-bit pattern. Rejection of a request that arrives mid-lookup is reached by holding the request valid with changed fields through the whole lookup.

// File: rtl/acmp_pkg.sv
package acmp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_VP_READ = 2'd1,
    ST_VC_READ = 2'd2,
    ST_DONE    = 2'd3
  } acmp_state_e;

endpackage

// File: rtl/acmp_compact.sv
// Packs the bits of data_i selected by mask_i into the low end of idx_o,
// lowest selected bit first.
module acmp_compact #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] idx_o
);

  always_comb begin
    int unsigned pos;
    pos   = 0;
    idx_o = '0;
    for (int unsigned i = 0; i < W; i++) begin
      if (mask_i[i]) begin
        idx_o = idx_o | (W'(data_i[i]) << pos);
        pos   = pos + 1;
      end
    end
  end

endmodule

// File: rtl/acmp_fsm.sv
module acmp_fsm
  import acmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        ack_i,
  output acmp_state_e state_o,
  output logic        rd_en_o,
  output logic        vp_load_o,
  output logic        vc_load_o
);

  acmp_state_e state_q, state_d;
  logic        wait_q, wait_d;

  always_comb begin
    state_d   = state_q;
    wait_d    = 1'b0;
    rd_en_o   = 1'b0;
    vp_load_o = 1'b0;
    vc_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_VP_READ;
      end
      ST_VP_READ: begin
        if (!wait_q) begin
          rd_en_o = 1'b1;
          wait_d  = 1'b1;
        end else begin
          vp_load_o = 1'b1;
          state_d   = ST_VC_READ;
        end
      end
      ST_VC_READ: begin
        if (!wait_q) begin
          rd_en_o = 1'b1;
          wait_d  = 1'b1;
        end else begin
          vc_load_o = 1'b1;
          state_d   = ST_DONE;
        end
      end
      ST_DONE: begin
        if (ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/atm_addr_compressor.sv
module atm_addr_compressor
  import acmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PORT_W = 5,
  parameter int unsigned VPI_W  = 12,
  parameter int unsigned VCI_W  = 16,
  parameter int unsigned CODE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       multi_port,
  input  logic [PORT_W-1+VPI_W-1:0]  vp_mask,
  input  logic [ADDR_W-1:0]          vpt_base0,
  input  logic [ADDR_W-1:0]          vct_base0,
  input  logic [ADDR_W-1:0]          vpt_base1,
  input  logic [ADDR_W-1:0]          vct_base1,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [PORT_W-1:0]          req_port,
  input  logic [VPI_W-1:0]           req_vpi,
  input  logic [VCI_W-1:0]           req_vci,
  output logic                       mem_rd_en,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic [2*VCI_W-1:0]         mem_rdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ack,
  output logic [CODE_W-1:0]          rsp_code,
  output logic                       rsp_miss
);

  localparam int unsigned PSEL_W = PORT_W - 1;
  localparam int unsigned KEY_W  = PSEL_W + VPI_W;
  localparam int unsigned WORD_W = 2 * VCI_W;
  localparam int unsigned ENT_SH = $clog2(WORD_W / 8);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // control
  acmp_state_e state;
  logic        rd_en, vp_load, vc_load, accept;

  acmp_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (accept),
    .ack_i     (rsp_ack),
    .state_o   (state),
    .rd_en_o   (rd_en),
    .vp_load_o (vp_load),
    .vc_load_o (vc_load)
  );

  assign req_ready = (state == ST_IDLE) && rst_int_n;
  assign accept    = req_valid && req_ready;

  // request capture
  logic [KEY_W-1:0]  key_d, key_q;
  logic [VCI_W-1:0]  vci_q;
  logic              set_d, set_q;

  assign key_d = {(multi_port ? req_port[PSEL_W-1:0] : {PSEL_W{1'b0}}), req_vpi};
  assign set_d = multi_port & req_port[PORT_W-1];

  // entry fields
  logic [VCI_W-1:0]  vc_mask_q;
  logic [VCI_W-1:0]  vc_off_q;
  logic [CODE_W-1:0] code_q;
  logic              miss_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      key_q     <= '0;
      vci_q     <= '0;
      set_q     <= 1'b0;
      vc_mask_q <= '0;
      vc_off_q  <= '0;
      code_q    <= '0;
      miss_q    <= 1'b0;
    end else begin
      if (accept) begin
        key_q <= key_d;
        vci_q <= req_vci;
        set_q <= set_d;
      end
      if (vp_load) begin
        vc_mask_q <= mem_rdata[WORD_W-1:VCI_W];
        vc_off_q  <= mem_rdata[VCI_W-1:0];
      end
      if (vc_load) begin
        code_q <= mem_rdata[WORD_W-1:WORD_W-CODE_W];
        miss_q <= mem_rdata[0];
      end
    end
  end

  // index packing for both levels
  logic [KEY_W-1:0] vp_idx;
  logic [VCI_W-1:0] vc_idx;

  acmp_compact #(.W(KEY_W)) vp_pack_i (
    .data_i (key_q),
    .mask_i (vp_mask),
    .idx_o  (vp_idx)
  );

  acmp_compact #(.W(VCI_W)) vc_pack_i (
    .data_i (vci_q),
    .mask_i (vc_mask_q),
    .idx_o  (vc_idx)
  );

  // address generation
  logic [ADDR_W-1:0] vpt_base, vct_base, vp_addr, vc_addr;

  assign vpt_base = set_q ? vpt_base1 : vpt_base0;
  assign vct_base = set_q ? vct_base1 : vct_base0;
  assign vp_addr  = vpt_base + ADDR_W'({vp_idx, {ENT_SH{1'b0}}});
  assign vc_addr  = vct_base + ADDR_W'(vc_off_q) + ADDR_W'({vc_idx, {ENT_SH{1'b0}}});

  assign mem_rd_en = rd_en;
  assign mem_addr  = (state == ST_VC_READ) ? vc_addr : vp_addr;

  assign rsp_valid = (state == ST_DONE);
  assign rsp_code  = code_q;
  assign rsp_miss  = miss_q;

endmodule

// File: rtl/acmp_checker.sv
module acmp_checker #(
  parameter int unsigned CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd_en,
  input logic              rsp_valid,
  input logic              rsp_ack,
  input logic [CODE_W-1:0] rsp_code,
  input logic              rsp_miss
);

  assert_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_rd_en));

  assert_read_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_accept_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_en);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_miss)));

  assert_rsp_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack) |=> (!rsp_valid && req_ready));

endmodule

bind atm_addr_compressor acmp_checker #(.CODE_W(CODE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_rd_en (mem_rd_en),
  .rsp_valid (rsp_valid),
  .rsp_ack   (rsp_ack),
  .rsp_code  (rsp_code),
  .rsp_miss  (rsp_miss)
);

// File: tb/atm_addr_compressor_tb_top.sv
module atm_addr_compressor_tb_top;

  localparam logic [31:0] VPT0 = 32'h0000_0100;
  localparam logic [31:0] VCT0 = 32'h0000_0400;
  localparam logic [31:0] VPT1 = 32'h0000_0204;
  localparam logic [31:0] VCT1 = 32'hFFFF_F800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        multi_port;
  logic [15:0] vp_mask;
  logic [31:0] vpt_base0, vct_base0, vpt_base1, vct_base1;
  logic        req_valid, req_ready;
  logic [4:0]  req_port;
  logic [11:0] req_vpi;
  logic [15:0] req_vci;
  logic        mem_rd_en;
  logic [31:0] mem_addr, mem_rdata;
  logic        rsp_valid, rsp_ack;
  logic [15:0] rsp_code;
  logic        rsp_miss;

  int errors = 0;
  int checks = 0;
  logic [31:0] last_vp;

  always #5 clk = ~clk;

  atm_addr_compressor dut_i (
    .clk (clk), .rst_n (rst_n), .multi_port (multi_port), .vp_mask (vp_mask),
    .vpt_base0 (vpt_base0), .vct_base0 (vct_base0),
    .vpt_base1 (vpt_base1), .vct_base1 (vct_base1),
    .req_valid (req_valid), .req_ready (req_ready), .req_port (req_port),
    .req_vpi (req_vpi), .req_vci (req_vci),
    .mem_rd_en (mem_rd_en), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid), .rsp_ack (rsp_ack), .rsp_code (rsp_code), .rsp_miss (rsp_miss)
  );

  function automatic logic [31:0] fmem(input logic [9:0] w);
    logic [31:0] h;
    h = {22'd0, w} * 32'h9E37_79B1;
    h = h ^ (h >> 13) ^ 32'h0000_5A5A;
    return h;
  endfunction

  function automatic logic [15:0] pack_bits(input logic [15:0] d, input logic [15:0] m);
    logic [15:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        r = r | (16'(d[i]) << k);
        k++;
      end
    end
    return r;
  endfunction

  // synchronous table memory, one cycle of latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= fmem(mem_addr[11:2]);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [4:0] p, input logic [11:0] v, input logic [15:0] c,
                           input logic mp, input logic [15:0] m, input bit busy_req,
                           input int ack_dly, input string vp_tag);
    logic [15:0] key;
    logic        set;
    logic [31:0] exp_vp, exp_vc, ent_vp, ent_vc, got_vp, got_vc;
    logic [15:0] held_code;
    logic        held_miss;
    int          cyc, nrd;
    bit          busy_ok;
    key    = {(mp ? p[3:0] : 4'h0), v};
    set    = mp & p[4];
    exp_vp = (set ? VPT1 : VPT0) + ({16'd0, pack_bits(key, m)} << 2);
    ent_vp = fmem(exp_vp[11:2]);
    exp_vc = (set ? VCT1 : VCT0) + {16'd0, ent_vp[15:0]}
             + ({16'd0, pack_bits(c, ent_vp[31:16])} << 2);
    ent_vc = fmem(exp_vc[11:2]);
    got_vp = '0;
    got_vc = '0;

    @(negedge clk);
    multi_port = mp; vp_mask = m;
    req_port = p; req_vpi = v; req_vci = c; req_valid = 1'b1;
    @(negedge clk);
    if (busy_req) begin
      req_port = ~p; req_vpi = ~v; req_vci = ~c;
    end else begin
      req_valid = 1'b0;
    end
    cyc = 1; nrd = 0; busy_ok = 1;
    while (!rsp_valid && cyc < 20) begin
      if (req_ready) busy_ok = 0;
      if (mem_rd_en) begin
        if (nrd == 0) got_vp = mem_addr;
        else          got_vc = mem_addr;
        nrd++;
      end
      @(negedge clk);
      cyc++;
    end
    last_vp = got_vp;
    chk(cyc == 5, "R6 latency", 32'(cyc), 32'd5);
    chk(nrd == 2, "R6 read count", 32'(nrd), 32'd2);
    chk(busy_ok && !req_ready, "R7 busy not ready", {31'd0, busy_ok}, 32'd1);
    chk(got_vp == exp_vp, vp_tag, got_vp, exp_vp);
    chk(got_vc == exp_vc, "R4 vc address", got_vc, exp_vc);
    chk(rsp_code == ent_vc[31:16], "R5 code", {16'd0, rsp_code}, {16'd0, ent_vc[31:16]});
    chk(rsp_miss == ent_vc[0], "R5 miss", {31'd0, rsp_miss}, {31'd0, ent_vc[0]});
    if (m == 16'h07F0) begin
      chk(got_vp == (set ? VPT1 : VPT0) + {21'd0, key[10:4], 2'b00}, "R9 0x07F0 field",
          got_vp, (set ? VPT1 : VPT0) + {21'd0, key[10:4], 2'b00});
    end
    held_code = rsp_code;
    held_miss = rsp_miss;
    for (int d = 0; d < ack_dly; d++) @(negedge clk);
    if (ack_dly > 0) begin
      chk(rsp_valid && rsp_code == held_code && rsp_miss == held_miss, "R8 hold",
          {15'd0, rsp_valid, rsp_code}, {15'd0, 1'b1, held_code});
    end
    rsp_ack = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(!rsp_valid && req_ready, "R8 release", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    multi_port = 1'b1; vp_mask = '0;
    vpt_base0 = VPT0; vct_base0 = VCT0; vpt_base1 = VPT1; vct_base1 = VCT1;
    req_valid = 1'b0; req_port = '0; req_vpi = '0; req_vci = '0; rsp_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_rd_en && !req_ready, "R1 in reset",
        {29'd0, rsp_valid, mem_rd_en, req_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R1 after release",
        {29'd0, rsp_valid, mem_rd_en, req_ready}, 32'd1);

    begin
      logic [15:0] masks [8];
      string tag;
      masks = '{16'h0000, 16'hFFFF, 16'h000F, 16'hF000, 16'hA5A5, 16'h5A3C, 16'hF01F, 16'h07F0};
      for (int mi = 0; mi < 8; mi++) begin
        for (int p = 0; p < 32; p++) begin
          if (masks[mi] == 16'h0000 || masks[mi] == 16'hFFFF) tag = "R9 vp address";
          else if (p >= 16)                                  tag = "R3 vp address set1";
          else                                               tag = "R2 vp address";
          do_lookup(5'(p), 12'(p * 12'h135 + mi * 7), 16'(p * 16'h1F3B) ^ 16'(mi * 16'h0101),
                    1'b1, masks[mi], (p % 5) == 0, p % 3, tag);
        end
      end
      // single-port mode: port number ignored, set 0 used
      for (int p = 0; p < 32; p++) begin
        do_lookup(5'(p), 12'(12'hA53 ^ p), 16'(16'hC0DE + p * 3), 1'b0, 16'hF0FF,
                  (p % 7) == 3, p % 2, "R3 single-port vp address");
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule